// File: doc/BRIEF.md
# ECC Error Event Capture Unit

This block sits beside a memory's error-correction logic and keeps a record of the most recent error event. The checker raises one of two pulses. One pulse marks a correctable single-bit error. The other marks a non-correctable multi-bit error. Each pulse comes with the bus access that caused it: address, transfer size, protection attributes, master identifier and the value on the data bus.

Each error type has its own enable. An event whose type is disabled leaves the unit untouched. An enabled event loads the access details into read-only capture registers and sets a sticky flag for its type. Software reads the captured values through a small register port. It clears a flag by writing one to that flag's bit.

A read returns its data one cycle later. After a non-correctable error the captured data word is undefined, and software must not rely on it.

Top module: `ecc_evt_capture`

## Requirements
- R1: After reset, reading word 0 (status), word 1 (address) and word 2 (attributes) returns zero.
- R2: An enabled correctable event sets status bit 0. It also captures the address into word 1, the attributes into word 2 and the data bus value into word 3.
- R3: An enabled non-correctable event sets status bit 1 and captures the address and attributes. The data word is undefined afterwards.
- R4: An event whose type is disabled changes no flag and no captured value.
- R5: The capture registers hold the most recent enabled event. A newer event overwrites all captured fields of an older one.
- R6: Status bit 2 tells which type was captured last (1 = non-correctable, 0 = correctable). When both pulses arrive in the same cycle and both types are enabled, both flags are set and the non-correctable event is the one recorded. When only one of the two types is enabled, that type is recorded.
- R7: The attribute word holds the fields as follows:
  - bits 2:0 hold the size code: 000 = 8-bit, 001 = 16-bit, 010 = 32-bit, 1xx reserved.
  - bits 7:4 hold the protection field: bit 7 cacheable, bit 6 bufferable, bit 5 supervisor, bit 4 data (0 = instruction fetch).
  - bit 3 is zero.
  - the master identifier starts at bit 8.
- R8: Writes to words 1, 2 and 3 have no effect.
- R9: A write to word 0 clears each flag whose write-data bit is 1 and leaves flags whose write-data bit is 0. A flag set and a clear of that flag in the same cycle leave the flag set. Bit 2 is not cleared by writes.
- R10: Read data appears in the cycle after the read strobe. A read in the same cycle as a capture returns the value held before that capture. Indices 4 to 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| evt_corr | input | 1 | Correctable (single-bit) error pulse |
| evt_uncorr | input | 1 | Non-correctable (multi-bit) error pulse |
| cfg_corr_en | input | 1 | Capture enable for correctable events |
| cfg_uncorr_en | input | 1 | Capture enable for non-correctable events |
| acc_addr | input | ADDR_W | Address of the faulting access |
| acc_size | input | 3 | Transfer size code of the access |
| acc_prot | input | 4 | Protection attributes of the access |
| acc_master | input | MID_W | Identifier of the bus master |
| acc_data | input | DATA_W | Data bus value of the access |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | RIDX_W | Register word index |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, valid one cycle after the strobe |

## Verification
The bench drives events with one type enabled and with that type disabled. A unit that ignored the enables would show a stale address replaced or a flag raised.

It fires both pulses in one cycle, once with both types enabled and once with only the correctable type enabled. This exposes a wrong priority: the status type bit would flip or the flags would be set wrongly.

Two other collisions are tested: a read in the same cycle as a capture, and a flag clear in the same cycle as a flag set. These catch a read path that passes new data straight through and a clear that beats the set.

Writes of all ones to the read-only words, and writes of zero to the status word, check that nothing moves when it should not.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;

  typedef enum logic {
    KIND_COR = 1'b0,
    KIND_UNC = 1'b1
  } evt_kind_e;

  typedef struct packed {
    logic [3:0] prot;
    logic [2:0] size;
  } bus_attr_t;

  // register word indices
  localparam int IDX_STATUS = 0;
  localparam int IDX_ADDR   = 1;
  localparam int IDX_ATTR   = 2;
  localparam int IDX_DATA   = 3;
  localparam int NUM_WORDS  = 4;

  // status word bits
  localparam int ST_COR  = 0;
  localparam int ST_UNC  = 1;
  localparam int ST_KIND = 2;

  // attribute word field positions
  localparam int ATTR_SIZE_LSB = 0;
  localparam int ATTR_PROT_LSB = 4;
  localparam int ATTR_MID_LSB  = 8;

endpackage

// File: rtl/ecc_rst_sync.sv
module ecc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/ecc_evt_select.sv
module ecc_evt_select
  import ecc_cap_pkg::*;
(
  input  logic      evt_corr,
  input  logic      evt_uncorr,
  input  logic      en_corr,
  input  logic      en_uncorr,
  output logic      take_corr,
  output logic      take_uncorr,
  output logic      load,
  output evt_kind_e kind
);

  always_comb begin
    take_corr   = evt_corr & en_corr;
    take_uncorr = evt_uncorr & en_uncorr;
    load        = take_corr | take_uncorr;
    // the non-correctable event takes the capture slot when both qualify
    kind        = take_uncorr ? KIND_UNC : KIND_COR;
  end

endmodule

// File: rtl/ecc_cap_regs.sv
module ecc_cap_regs
  import ecc_cap_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int MID_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  evt_kind_e         kind_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  bus_attr_t         attr_in,
  input  logic [MID_W-1:0]  mid_in,
  input  logic [DATA_W-1:0] data_in,
  output evt_kind_e         kind_q,
  output logic [ADDR_W-1:0] addr_q,
  output bus_attr_t         attr_q,
  output logic [MID_W-1:0]  mid_q,
  output logic [DATA_W-1:0] data_q
);

  evt_kind_e         kind_d;
  logic [ADDR_W-1:0] addr_d;
  bus_attr_t         attr_d;
  logic [MID_W-1:0]  mid_d;
  logic [DATA_W-1:0] data_d;

  always_comb begin
    kind_d = kind_q;
    addr_d = addr_q;
    attr_d = attr_q;
    mid_d  = mid_q;
    data_d = data_q;
    if (load) begin
      kind_d = kind_in;
      addr_d = addr_in;
      attr_d = attr_in;
      mid_d  = mid_in;
      data_d = data_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= KIND_COR;
      addr_q <= '0;
      attr_q <= '0;
      mid_q  <= '0;
    end else begin
      kind_q <= kind_d;
      addr_q <= addr_d;
      attr_q <= attr_d;
      mid_q  <= mid_d;
    end
  end

  // the data word has no defined reset value
  always_ff @(posedge clk) begin
    data_q <= data_d;
  end

  p_hold_when_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(addr_q) && $stable(attr_q) && $stable(mid_q) && $stable(kind_q)));

  p_newest_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (addr_q == $past(addr_in) && attr_q == $past(attr_in) && mid_q == $past(mid_in)));

endmodule

// File: rtl/ecc_cap_flags.sv
module ecc_cap_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_cor,
  input  logic       set_unc,
  input  logic       clr_en,
  input  logic [1:0] clr_mask,
  output logic       cor_q,
  output logic       unc_q
);

  logic cor_d;
  logic unc_d;

  always_comb begin
    cor_d = cor_q;
    unc_d = unc_q;
    if (clr_en) begin
      cor_d = cor_d & ~clr_mask[0];
      unc_d = unc_d & ~clr_mask[1];
    end
    // a new event outranks a clear in the same cycle
    if (set_cor) cor_d = 1'b1;
    if (set_unc) unc_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cor_q <= 1'b0;
      unc_q <= 1'b0;
    end else begin
      cor_q <= cor_d;
      unc_q <= unc_d;
    end
  end

  p_cor_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_cor |=> cor_q);

  p_unc_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    set_unc |=> unc_q);

  p_cor_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cor_q && !(clr_en && clr_mask[0])) |=> cor_q);

  p_unc_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (unc_q && !(clr_en && clr_mask[1])) |=> unc_q);

endmodule

// File: rtl/ecc_cap_rdport.sv
module ecc_cap_rdport #(
  parameter int DATA_W  = 32,
  parameter int NWORDS  = 4,
  parameter int RIDX_W  = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          rd,
  input  logic [RIDX_W-1:0]             idx,
  input  logic [NWORDS-1:0][DATA_W-1:0] words,
  output logic [DATA_W-1:0]             rdata_q
);

  localparam int SEL_W = (NWORDS > 1) ? $clog2(NWORDS) : 1;
  localparam logic [RIDX_W-1:0] LAST_IDX = RIDX_W'(NWORDS - 1);

  logic [DATA_W-1:0] rdata_d;

  always_comb begin
    rdata_d = rdata_q;
    if (rd) begin
      if (idx <= LAST_IDX) rdata_d = words[idx[SEL_W-1:0]];
      else                 rdata_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

endmodule

// File: rtl/ecc_evt_capture.sv
module ecc_evt_capture
  import ecc_cap_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int MID_W  = 4,
  parameter int RIDX_W = 3
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              evt_corr,
  input  logic              evt_uncorr,
  input  logic              cfg_corr_en,
  input  logic              cfg_uncorr_en,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [2:0]        acc_size,
  input  logic [3:0]        acc_prot,
  input  logic [MID_W-1:0]  acc_master,
  input  logic [DATA_W-1:0] acc_data,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [RIDX_W-1:0] reg_idx,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata
);

  localparam logic [RIDX_W-1:0] IX_STAT = RIDX_W'(IDX_STATUS);
  localparam logic [RIDX_W-1:0] IX_ADDR = RIDX_W'(IDX_ADDR);

  logic      rst_n;
  logic      take_corr;
  logic      take_uncorr;
  logic      load;
  evt_kind_e kind_sel;
  evt_kind_e kind_q;
  bus_attr_t attr_in;
  bus_attr_t attr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [MID_W-1:0]  mid_q;
  logic [DATA_W-1:0] data_q;
  logic cor_q;
  logic unc_q;
  logic clr_en;
  logic [NUM_WORDS-1:0][DATA_W-1:0] words;
  logic unused_wdata_hi;

  ecc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .arst_n     (arst_n),
    .rst_n_sync (rst_n)
  );

  ecc_evt_select u_sel (
    .evt_corr    (evt_corr),
    .evt_uncorr  (evt_uncorr),
    .en_corr     (cfg_corr_en),
    .en_uncorr   (cfg_uncorr_en),
    .take_corr   (take_corr),
    .take_uncorr (take_uncorr),
    .load        (load),
    .kind        (kind_sel)
  );

  always_comb begin
    attr_in.size = acc_size;
    attr_in.prot = acc_prot;
  end

  ecc_cap_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MID_W(MID_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .kind_in (kind_sel),
    .addr_in (acc_addr),
    .attr_in (attr_in),
    .mid_in  (acc_master),
    .data_in (acc_data),
    .kind_q  (kind_q),
    .addr_q  (addr_q),
    .attr_q  (attr_q),
    .mid_q   (mid_q),
    .data_q  (data_q)
  );

  assign clr_en          = reg_wr && (reg_idx == IX_STAT);
  assign unused_wdata_hi = ^reg_wdata[DATA_W-1:2];

  ecc_cap_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_cor  (take_corr),
    .set_unc  (take_uncorr),
    .clr_en   (clr_en),
    .clr_mask (reg_wdata[1:0]),
    .cor_q    (cor_q),
    .unc_q    (unc_q)
  );

  // assemble the readable words; writes reach only the status flags
  always_comb begin
    words = '0;
    words[IDX_STATUS][ST_COR]  = cor_q;
    words[IDX_STATUS][ST_UNC]  = unc_q;
    words[IDX_STATUS][ST_KIND] = (kind_q == KIND_UNC);
    words[IDX_ADDR]            = DATA_W'(addr_q);
    words[IDX_ATTR][ATTR_SIZE_LSB +: 3]     = attr_q.size;
    words[IDX_ATTR][ATTR_PROT_LSB +: 4]     = attr_q.prot;
    words[IDX_ATTR][ATTR_MID_LSB +: MID_W]  = mid_q;
    words[IDX_DATA]            = data_q;
  end

  ecc_cap_rdport #(.DATA_W(DATA_W), .NWORDS(NUM_WORDS), .RIDX_W(RIDX_W)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd      (reg_rd),
    .idx     (reg_idx),
    .words   (words),
    .rdata_q (reg_rdata)
  );

  p_unc_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_uncorr && cfg_uncorr_en) |=> (kind_q == KIND_UNC));

  p_disabled_no_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cor_q && !(evt_corr && cfg_corr_en)) |=> !cor_q);

  p_ro_words_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_idx != IX_STAT && !load) |=> ($stable(addr_q) && $stable(attr_q)));

  p_read_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_idx == IX_ADDR) |=> (reg_rdata == DATA_W'($past(addr_q))));

endmodule

// File: tb/sim_ecc_evt_capture.sv
`timescale 1ns/100ps
module sim_ecc_evt_capture;

  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int MID_W  = 4;
  localparam int RIDX_W = 3;

  typedef struct {
    logic [DATA_W-1:0] exp;
    string             tag;
  } item_t;

  logic              clk = 1'b0;
  logic              arst_n = 1'b0;
  logic              evt_corr = 1'b0;
  logic              evt_uncorr = 1'b0;
  logic              cfg_corr_en = 1'b0;
  logic              cfg_uncorr_en = 1'b0;
  logic [ADDR_W-1:0] acc_addr = '0;
  logic [2:0]        acc_size = '0;
  logic [3:0]        acc_prot = '0;
  logic [MID_W-1:0]  acc_master = '0;
  logic [DATA_W-1:0] acc_data = '0;
  logic              reg_rd = 1'b0;
  logic              reg_wr = 1'b0;
  logic [RIDX_W-1:0] reg_idx = '0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;

  int    n_checks = 0;
  int    n_errors = 0;
  bit    rd_seen  = 1'b0;
  bit    done     = 1'b0;
  item_t sb_q[$];

  always #2.5 clk = ~clk;

  ecc_evt_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MID_W(MID_W), .RIDX_W(RIDX_W)) u0 (
    .clk (clk), .arst_n (arst_n),
    .evt_corr (evt_corr), .evt_uncorr (evt_uncorr),
    .cfg_corr_en (cfg_corr_en), .cfg_uncorr_en (cfg_uncorr_en),
    .acc_addr (acc_addr), .acc_size (acc_size), .acc_prot (acc_prot),
    .acc_master (acc_master), .acc_data (acc_data),
    .reg_rd (reg_rd), .reg_wr (reg_wr), .reg_idx (reg_idx),
    .reg_wdata (reg_wdata), .reg_rdata (reg_rdata)
  );

  // attribute word layout per R7
  function automatic logic [DATA_W-1:0] attr_of(logic [2:0] sz, logic [3:0] pr, logic [MID_W-1:0] m);
    logic [DATA_W-1:0] w;
    w = '0;
    w[2:0] = sz;
    w[7:4] = pr;
    w[8 +: MID_W] = m;
    return w;
  endfunction

  // monitor: one scoreboard item per completed read
  always @(posedge clk) rd_seen <= reg_rd;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (sb_q.size() == 0) begin
        n_checks++;
        n_errors++;
        $display("FAIL scoreboard empty: read data %h with no expected item", reg_rdata);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        n_checks++;
        if (reg_rdata !== it.exp) begin
          n_errors++;
          $display("FAIL %s: got %h expected %h", it.tag, reg_rdata, it.exp);
        end
      end
    end
  end

  task automatic do_read(input int idx, input logic [DATA_W-1:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    reg_rd  = 1'b1;
    reg_idx = RIDX_W'(idx);
    it.exp = exp;
    it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic do_write(input int idx, input logic [DATA_W-1:0] wd);
    @(negedge clk);
    reg_wr    = 1'b1;
    reg_idx   = RIDX_W'(idx);
    reg_wdata = wd;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic set_bus(input logic [ADDR_W-1:0] a, input logic [2:0] sz, input logic [3:0] pr,
                         input logic [MID_W-1:0] m, input logic [DATA_W-1:0] d);
    acc_addr   = a;
    acc_size   = sz;
    acc_prot   = pr;
    acc_master = m;
    acc_data   = d;
  endtask

  task automatic fire(input bit c, input bit u, input logic [ADDR_W-1:0] a, input logic [2:0] sz,
                      input logic [3:0] pr, input logic [MID_W-1:0] m, input logic [DATA_W-1:0] d);
    @(negedge clk);
    set_bus(a, sz, pr, m, d);
    evt_corr   = c;
    evt_uncorr = u;
    @(negedge clk);
    evt_corr   = 1'b0;
    evt_uncorr = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset values
    do_read(0, 32'h0, "R1 status after reset");
    do_read(1, 32'h0, "R1 address after reset");
    do_read(2, 32'h0, "R1 attributes after reset");

    cfg_corr_en   = 1'b1;
    cfg_uncorr_en = 1'b1;

    // R2 / R7: correctable capture
    fire(1, 0, 32'h1000_0040, 3'b010, 4'b1010, 4'h5, 32'hDEAD_BEEF);
    do_read(0, 32'h1, "R2 correctable flag");
    do_read(1, 32'h1000_0040, "R2 captured address");
    do_read(2, attr_of(3'b010, 4'b1010, 4'h5), "R7 attribute layout 32-bit");
    do_read(3, 32'hDEAD_BEEF, "R2 captured data");

    // R8: read-only capture words
    do_write(1, 32'hFFFF_FFFF);
    do_write(2, 32'hFFFF_FFFF);
    do_write(3, 32'h0000_0000);
    do_read(1, 32'h1000_0040, "R8 address ignores write");
    do_read(2, attr_of(3'b010, 4'b1010, 4'h5), "R8 attributes ignore write");
    do_read(3, 32'hDEAD_BEEF, "R8 data ignores write");

    // R9: write one clears
    do_write(0, 32'h1);
    do_read(0, 32'h0, "R9 clear correctable flag");

    // R3: non-correctable capture (data word not checked)
    fire(0, 1, 32'h2000_0008, 3'b000, 4'b0101, 4'h3, 32'h1234_5678);
    do_read(0, 32'h6, "R3 non-correctable flag and type");
    do_read(1, 32'h2000_0008, "R3 captured address");
    do_read(2, attr_of(3'b000, 4'b0101, 4'h3), "R7 attribute layout 8-bit");

    // R9: zero bits leave flags, type bit survives clears
    do_write(0, 32'h0);
    do_read(0, 32'h6, "R9 write zero keeps flags");
    do_write(0, 32'h1);
    do_read(0, 32'h6, "R9 clear of other flag keeps this one");
    do_write(0, 32'hFFFF_FFFF);
    do_read(0, 32'h4, "R9 clear both flags keeps type bit");

    // R4: disabled types are ignored
    cfg_corr_en = 1'b0;
    fire(1, 0, 32'h3000_0000, 3'b001, 4'b1111, 4'h9, 32'h0);
    do_read(0, 32'h4, "R4 disabled correctable sets no flag");
    do_read(1, 32'h2000_0008, "R4 disabled correctable keeps address");
    cfg_corr_en   = 1'b1;
    cfg_uncorr_en = 1'b0;
    fire(0, 1, 32'h4000_0000, 3'b001, 4'b1111, 4'h9, 32'h0);
    do_read(0, 32'h4, "R4 disabled non-correctable sets no flag");
    do_read(1, 32'h2000_0008, "R4 disabled non-correctable keeps address");

    // R6: simultaneous events
    cfg_uncorr_en = 1'b1;
    fire(1, 1, 32'h5000_0010, 3'b001, 4'b1111, 4'h7, 32'hAAAA_5555);
    do_read(0, 32'h7, "R6 both enabled: both flags, non-correctable recorded");
    do_read(1, 32'h5000_0010, "R6 both enabled address");
    do_read(2, attr_of(3'b001, 4'b1111, 4'h7), "R7 attribute layout 16-bit");
    do_write(0, 32'h3);
    cfg_uncorr_en = 1'b0;
    fire(1, 1, 32'h6000_0020, 3'b010, 4'b0001, 4'h2, 32'h0BAD_F00D);
    do_read(0, 32'h1, "R6 only correctable enabled");
    do_read(1, 32'h6000_0020, "R6 only correctable enabled address");
    cfg_uncorr_en = 1'b1;

    // R5: newest overwrites
    fire(1, 0, 32'h7000_0000, 3'b000, 4'b0010, 4'h1, 32'h7777_7777);
    fire(1, 0, 32'h8000_0004, 3'b001, 4'b0100, 4'hC, 32'h8888_8888);
    do_read(1, 32'h8000_0004, "R5 newest address");
    do_read(2, attr_of(3'b001, 4'b0100, 4'hC), "R5 newest attributes");
    do_read(3, 32'h8888_8888, "R5 newest data");

    // R10: read coinciding with capture returns old value
    @(negedge clk);
    set_bus(32'h9000_0000, 3'b010, 4'b0011, 4'hE, 32'h9999_9999);
    evt_corr = 1'b1;
    reg_rd   = 1'b1;
    reg_idx  = 3'd1;
    begin
      item_t it;
      it.exp = 32'h8000_0004;
      it.tag = "R10 read during capture returns old";
      sb_q.push_back(it);
    end
    @(negedge clk);
    evt_corr = 1'b0;
    reg_rd   = 1'b0;
    do_read(1, 32'h9000_0000, "R10 read after capture returns new");
    do_read(5, 32'h0, "R10 unmapped index reads zero");
    do_read(7, 32'h0, "R10 top index reads zero");

    // R9: set wins over clear in the same cycle
    do_write(0, 32'h3);
    @(negedge clk);
    set_bus(32'hA000_0000, 3'b000, 4'b0000, 4'h0, 32'h0);
    evt_corr  = 1'b1;
    reg_wr    = 1'b1;
    reg_idx   = 3'd0;
    reg_wdata = 32'h1;
    @(negedge clk);
    evt_corr = 1'b0;
    reg_wr   = 1'b0;
    do_read(0, 32'h1, "R9 set beats clear");

    repeat (3) @(negedge clk);
    if (sb_q.size() != 0) begin
      n_checks++;
      n_errors++;
      $display("FAIL scoreboard: got %0d pending expected 0", sb_q.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule